// File: doc/BRIEF.md
# Serial Bus Start/Stop Control Register

This block is the control and status register of a two-wire serial bus channel. Software uses it to put start and stop conditions on the bus and to drive an acknowledge by hand. It also reads back flags that record the start and stop conditions seen on the bus. The CPU side accepts full byte writes and single-bit writes, and the whole register can be read at any time.

On the bus side, the block runs SDA and SCL through synchronisers and detects start and stop conditions there. It owns the serial data output latch and produces an open-drain pull-low output for SDA. Three plain inputs supply clear events from the rest of the channel: a channel enable, a transfer-start strobe and an address-mismatch strobe. The block carries no data stream, so every pin is a plain level or a one-cycle strobe, with no handshake.

Top module: `ssc_bus_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, the output latch `so_latch` is 1 and `sda_pull_low` is 0. The register bits, from bit 7 down to bit 0, are: bus-busy enable, ack-detected (read-only), ack enable, ack-drive (ACKT), start-detected (read-only), stop-detected (read-only), start command, stop command.
- R2: Writes to bits 6, 3 and 2 are ignored. Bits 7 and 5 store the value written and read it back.
- R3: A byte write (`wr_byte_en`, `wr_data`) updates every writable bit. A bit write (`wr_bit_en`, `wr_bit_sel`, `wr_bit_val`) updates only the bit selected by `wr_bit_sel` (0 to 7). If both come in the same cycle, the byte write is used.
- R4: When the start command bit (bit 1) is written as 1, it reads 1 for one cycle. On the next cycle `so_latch` goes to 0 and the bit returns to 0.
- R5: When the stop command bit (bit 0) is written as 1, it reads 1 for one cycle. On the next cycle `so_latch` goes to 1 and the bit returns to 0. If both command bits are 1 together, the stop command wins.
- R6: The start-detected flag (bit 3) is set when synchronised SDA falls while synchronised SCL is high. It is cleared by `xfer_start` and by a detected stop condition.
- R7: The stop-detected flag (bit 2) is set when synchronised SDA rises while synchronised SCL is high. It is cleared by `xfer_start` and by `addr_miss`.
- R8: While the ack-drive bit (bit 4) is 1, `sda_pull_low` is 1. The bit clears at the next falling edge of synchronised SCL, and also on `xfer_start`. `sda_pull_low` is also 1 whenever `so_latch` is 0.
- R9: While `chan_en` is 0, bits 4 to 0 are held at 0. Writes to those bits have no effect, and `so_latch` keeps its value.
- R10: When a set condition and a clear condition occur in the same cycle, the clear wins. For example, writing the ack-drive bit as 1 in a cycle with `xfer_start` leaves the bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Full byte write strobe |
| wr_data | input | 8 | Byte write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_sel | input | 3 | Index of the bit to write |
| wr_bit_val | input | 1 | Value for the single-bit write |
| rd_data | output | 8 | Register contents |
| chan_en | input | 1 | Channel enable |
| xfer_start | input | 1 | Transfer-start strobe |
| addr_miss | input | 1 | Address-mismatch strobe during address reception |
| sda_in | input | 1 | SDA line level, asynchronous |
| scl_in | input | 1 | SCL line level, asynchronous |
| so_latch | output | 1 | Serial data output latch |
| sda_pull_low | output | 1 | Open-drain drive-low request for SDA |

## Verification
The bench builds the block with `SYNC_STAGES=2`. With that value, a bus edge reaches the flags about three cycles after it arrives at the pins. The bench waits a fixed six cycles after each line change, so the start, stop and SCL-falling paths are covered without depending on the exact latency. The default width keeps every single-bit select inside the eight register positions. This lets the bench reach each read-only position through a bit write.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = $clog2(REG_W);
  localparam int B_BSYE = 7;
  localparam int B_ACKD = 6;
  localparam int B_ACKE = 5;
  localparam int B_ACKT = 4;
  localparam int B_STRD = 3;
  localparam int B_STPD = 2;
  localparam int B_STRC = 1;
  localparam int B_STPC = 0;

  typedef struct packed {
    logic start_det;
    logic stop_det;
    logic scl_fall;
  } bus_ev_t;
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssc_cond_detect.sv
module ssc_cond_detect
  import ssc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sda_in,
  input  logic    scl_in,
  output bus_ev_t ev
);
  logic sda_s, scl_s, sda_d, scl_d;

  ssc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
  ssc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda_s;
      scl_d <= scl_s;
    end
  end

  always_comb begin
    ev.start_det = sda_d & ~sda_s & scl_s & scl_d;
    ev.stop_det  = ~sda_d & sda_s & scl_s & scl_d;
    ev.scl_fall  = scl_d & ~scl_s;
  end
endmodule

// File: rtl/ssc_ctrl_reg.sv
module ssc_ctrl_reg
  import ssc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_byte_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_bit_en,
  input  logic [SEL_W-1:0] wr_bit_sel,
  input  logic             wr_bit_val,
  input  logic             chan_en,
  input  logic             xfer_start,
  input  logic             addr_miss,
  input  bus_ev_t          ev,
  output logic [REG_W-1:0] regq,
  output logic             so_latch
);
  logic [REG_W-1:0] wmask, wval;
  logic bsye, acke, ackt, strd, stpd, strc, stpc;

  always_comb begin
    wmask = '0;
    wval  = '0;
    if (wr_byte_en) begin
      wmask = '1;
      wval  = wr_data;
    end else if (wr_bit_en) begin
      wmask = REG_W'(1) << wr_bit_sel;
      wval  = {REG_W{wr_bit_val}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsye <= 1'b0; acke <= 1'b0; ackt <= 1'b0;
      strd <= 1'b0; stpd <= 1'b0; strc <= 1'b0; stpc <= 1'b0;
      so_latch <= 1'b1;
    end else begin
      if (wmask[B_BSYE]) bsye <= wval[B_BSYE];
      if (wmask[B_ACKE]) acke <= wval[B_ACKE];
      if (chan_en) begin
        strc <= wmask[B_STRC] & wval[B_STRC];
        stpc <= wmask[B_STPC] & wval[B_STPC];
        ackt <= ~xfer_start & ~ev.scl_fall &
                (wmask[B_ACKT] ? wval[B_ACKT] : ackt);
        stpd <= ~xfer_start & ~addr_miss & (stpd | ev.stop_det);
        strd <= ~xfer_start & ~ev.stop_det & (strd | ev.start_det);
        if (stpc) so_latch <= 1'b1;
        else if (strc) so_latch <= 1'b0;
      end else begin
        strc <= 1'b0; stpc <= 1'b0; ackt <= 1'b0;
        stpd <= 1'b0; strd <= 1'b0;
      end
    end
  end

  always_comb begin
    regq = '0;
    regq[B_BSYE] = bsye;
    regq[B_ACKD] = 1'b0;
    regq[B_ACKE] = acke;
    regq[B_ACKT] = ackt;
    regq[B_STRD] = strd;
    regq[B_STPD] = stpd;
    regq[B_STRC] = strc;
    regq[B_STPC] = stpc;
  end
endmodule

// File: rtl/ssc_bus_ctrl.sv
module ssc_bus_ctrl
  import ssc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_byte_en,
  input  logic [7:0] wr_data,
  input  logic       wr_bit_en,
  input  logic [2:0] wr_bit_sel,
  input  logic       wr_bit_val,
  output logic [7:0] rd_data,
  input  logic       chan_en,
  input  logic       xfer_start,
  input  logic       addr_miss,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       so_latch,
  output logic       sda_pull_low
);
  bus_ev_t ev;
  logic [REG_W-1:0] regq;

  ssc_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in), .ev(ev));

  ssc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n),
    .wr_byte_en(wr_byte_en), .wr_data(wr_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .chan_en(chan_en), .xfer_start(xfer_start), .addr_miss(addr_miss),
    .ev(ev), .regq(regq), .so_latch(so_latch));

  assign rd_data      = regq;
  assign sda_pull_low = ~so_latch | regq[B_ACKT];
endmodule

// File: rtl/ssc_bus_ctrl_chk.sv
module ssc_bus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       chan_en,
  input logic       xfer_start,
  input logic       addr_miss,
  input logic       so_latch
);
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (rd_data[4:0] == 5'b0)); // R9
  AST_START_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rd_data[1] && !rd_data[0]) |=> !so_latch); // R4
  AST_STOP_CMD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && rd_data[0]) |=> so_latch); // R5
  AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (rd_data[4:2] == 3'b0)); // R10
  AST_MISS_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> !rd_data[2]); // R7
endmodule

bind ssc_bus_ctrl ssc_bus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .chan_en(chan_en),
  .xfer_start(xfer_start), .addr_miss(addr_miss), .so_latch(so_latch));

// File: tb/ssc_bus_ctrl_test.sv
`timescale 1ns/1ps
module ssc_bus_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic wr_byte_en = 0, wr_bit_en = 0, wr_bit_val = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_bit_sel = 0;
  logic chan_en = 1, xfer_start = 0, addr_miss = 0;
  logic sda_in = 1, scl_in = 1;
  logic [7:0] rd_data;
  logic so_latch, sda_pull_low;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssc_bus_ctrl #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_byte_en(wr_byte_en), .wr_data(wr_data),
    .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
    .rd_data(rd_data), .chan_en(chan_en), .xfer_start(xfer_start),
    .addr_miss(addr_miss), .sda_in(sda_in), .scl_in(scl_in),
    .so_latch(so_latch), .sda_pull_low(sda_pull_low));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wbyte(logic [7:0] d);
    @(negedge clk); wr_byte_en = 1; wr_data = d;
    @(negedge clk); wr_byte_en = 0;
  endtask

  task automatic wbit(logic [2:0] s, logic v);
    @(negedge clk); wr_bit_en = 1; wr_bit_sel = s; wr_bit_val = v;
    @(negedge clk); wr_bit_en = 0;
  endtask

  task automatic bus(logic sda, logic scl);
    @(negedge clk); sda_in = sda; scl_in = scl;
    wait_cyc(6);
  endtask

  task automatic t_reset;
    check("R1 reg", rd_data, 8'h00);
    check("R1 latch", {7'b0, so_latch}, 8'h01);
    check("R1 pull", {7'b0, sda_pull_low}, 8'h00);
  endtask

  task automatic t_ro_bits;
    wbyte(8'hEC);
    check("R2 byte ro", rd_data, 8'hA0);
    wbit(3'd6, 1); wbit(3'd3, 1); wbit(3'd2, 1);
    check("R2 bit ro", rd_data, 8'hA0);
  endtask

  task automatic t_bit_write;
    wbit(3'd7, 0);
    check("R3 bit7 clr", rd_data, 8'h20);
    @(negedge clk); wr_byte_en = 1; wr_data = 8'h80;
    wr_bit_en = 1; wr_bit_sel = 3'd5; wr_bit_val = 1;
    @(negedge clk); wr_byte_en = 0; wr_bit_en = 0;
    check("R3 byte wins", rd_data, 8'h80);
    wbyte(8'h00);
  endtask

  task automatic t_start_cmd;
    wbit(3'd1, 1);
    check("R4 cmd visible", rd_data, 8'h02);
    check("R4 latch hold", {7'b0, so_latch}, 8'h01);
    @(negedge clk);
    check("R4 self clear", rd_data, 8'h00);
    check("R4 latch low", {7'b0, so_latch}, 8'h00);
    check("R8 pull by latch", {7'b0, sda_pull_low}, 8'h01);
  endtask

  task automatic t_stop_cmd;
    wbyte(8'h03);
    check("R5 both visible", rd_data, 8'h03);
    @(negedge clk);
    check("R5 self clear", rd_data, 8'h00);
    check("R5 latch high", {7'b0, so_latch}, 8'h01);
  endtask

  task automatic t_conditions;
    bus(0, 1);
    check("R6 start set", rd_data, 8'h08);
    bus(0, 0); bus(1, 0); bus(1, 1);
    check("R6 no false cond", rd_data, 8'h08);
    bus(0, 1); bus(1, 1);
    check("R6 stop clears start", rd_data, 8'h04);
    @(negedge clk); addr_miss = 1;
    @(negedge clk); addr_miss = 0;
    check("R7 miss clears stop", rd_data, 8'h00);
    bus(0, 1); bus(1, 1);
    check("R7 stop set", rd_data, 8'h04);
    bus(0, 1);
    check("R6 start again", rd_data, 8'h0C);
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    check("R6 R7 xfer clears", rd_data, 8'h00);
  endtask

  task automatic t_ackt;
    bus(0, 0); bus(1, 0); bus(1, 1);
    wbit(3'd4, 1);
    check("R8 ackt set", rd_data, 8'h10);
    check("R8 pull by ackt", {7'b0, sda_pull_low}, 8'h01);
    bus(1, 0);
    check("R8 scl fall clears", rd_data, 8'h00);
    check("R8 pull released", {7'b0, sda_pull_low}, 8'h00);
    wbit(3'd4, 1);
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
    check("R8 xfer clears ackt", rd_data, 8'h00);
    bus(1, 1);
  endtask

  task automatic t_clear_wins;
    @(negedge clk); wr_bit_en = 1; wr_bit_sel = 3'd4; wr_bit_val = 1;
    xfer_start = 1;
    @(negedge clk); wr_bit_en = 0; xfer_start = 0;
    check("R10 clear wins", rd_data, 8'h00);
  endtask

  task automatic t_disable;
    bus(0, 1);
    wbit(3'd4, 1);
    check("R9 pre", rd_data, 8'h18);
    @(negedge clk); chan_en = 0;
    @(negedge clk);
    check("R9 cleared", rd_data, 8'h00);
    wbyte(8'h13);
    check("R9 writes blocked", rd_data, 8'h00);
    wait_cyc(2);
    check("R9 latch kept", {7'b0, so_latch}, 8'h01);
    wbit(3'd7, 1);
    check("R9 bsye still stores", rd_data, 8'h80);
    chan_en = 1;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ro_bits();
    t_bit_write();
    t_start_cmd();
    t_stop_cmd();
    t_conditions();
    t_ackt();
    t_clear_wins();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule